// File: doc/BRIEF.md
# Even/Odd Pixel Stream Reorderer

A split line sensor reads out its even-indexed and odd-indexed pixels on two separate paths. This block sits between the digitizer and the line store. Each input transfer carries one even pixel and its odd neighbour. The block sends them out as a single stream in strictly ascending pixel order, 0, 1, 2 up to the last pixel, and flags that last pixel.

Every accepted pair produces two output beats: the even pixel first, then the odd one. The odd pixel waits in a one-entry holding register, and the input is stalled while that register is full. The line length is a runtime input from 1 to `MAX_LEN` pixels. When the length is odd, the odd sample of the final pair has no place in the line and is dropped.

Top module: `pix_reorder`

## Requirements
- R1: After reset, `out_valid_o` and `out_last_o` are low and `in_ready_o` is high.
- R2: The even pixel of a pair accepted at a clock edge (`in_valid_i` and `in_ready_o` both high) is presented on `out_data_o` with `out_valid_o` high in the cycle after that edge.
- R3: Unless it is dropped under R6, the odd pixel of an accepted pair is presented in the cycle directly after its even pixel. An input held valid therefore yields one output beat per cycle.
- R4: `in_ready_o` is low for the one cycle in which an odd pixel occupies the holding register. A pair offered during that cycle is not taken, and it is accepted unchanged once `in_ready_o` returns high.
- R5: For a line length L (1 to `MAX_LEN`), exactly L beats are emitted per line, carrying pixels 0 to L-1 in ascending order. `out_last_o` is high on the beat for pixel L-1 and on no other beat.
- R6: When L is odd, the odd sample of pair (L-1)/2 never appears on the output. `in_ready_o` stays high after that pair is accepted.
- R7: After the last pair of a line, the next accepted pair is treated as pair 0 of a new line, so lines presented back to back come out in order, each with its own last flag.
- R8: `out_valid_o` is low in any cycle that follows an edge with no accepted pair and an empty holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_len_i | input | LEN_W | Pixels per line, 1 to MAX_LEN, held stable during a line |
| in_valid_i | input | 1 | Pixel pair is offered |
| in_ready_o | output | 1 | Pair can be accepted this cycle |
| even_i | input | PIX_W | Even-indexed pixel of the pair |
| odd_i | input | PIX_W | Odd-indexed pixel of the pair |
| out_valid_o | output | 1 | Output beat present |
| out_data_o | output | PIX_W | Output pixel |
| out_last_o | output | 1 | Beat carries the last pixel of the line |

## Verification
The bench drives even line lengths, which tell a correct even/odd interleave apart from swapped or repeated pixels. It drives odd lengths, which show whether the trailing odd sample is dropped and the flag moves to the even pixel. A length of one tests the degenerate single-pair line, and the maximum length tests the counter width. Back-to-back lines of different lengths show that the pair position wraps cleanly. An input held valid without pause shows that pairs offered during the hold cycle are neither taken nor lost, and an idle stretch shows that no beats appear without input.

// File: rtl/pix_reorder_pkg.sv
package pix_reorder_pkg;
  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_EVEN,
    SRC_HOLD
  } out_src_e;
endpackage

// File: rtl/pix_pair_ctr.sv
module pix_pair_ctr #(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] line_len_i,
  input  logic             step_i,
  output logic             last_pair_o,
  output logic             odd_len_o
);
  logic [LEN_W:0]   len_plus1;
  logic [LEN_W-1:0] n_pairs;
  logic [LEN_W-1:0] pair_idx;

  assign len_plus1   = {1'b0, line_len_i} + 1'b1;
  assign n_pairs     = len_plus1[LEN_W:1];
  assign odd_len_o   = line_len_i[0];
  assign last_pair_o = (pair_idx == n_pairs - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pair_idx <= '0;
    else if (step_i && last_pair_o) pair_idx <= '0;
    else if (step_i)                pair_idx <= pair_idx + 1'b1;
  end

  a_r7_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_pair_o) |=> (pair_idx == '0));
endmodule

// File: rtl/pix_merge.sv
module pix_merge
  import pix_reorder_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [PIX_W-1:0] even_i,
  input  logic [PIX_W-1:0] odd_i,
  input  logic             keep_odd_i,
  input  logic             even_last_i,
  input  logic             odd_last_i,
  output logic             hold_busy_o,
  output logic             out_valid_o,
  output logic [PIX_W-1:0] out_data_o,
  output logic             out_last_o
);
  logic             hold_valid;
  logic [PIX_W-1:0] hold_data;
  logic             hold_last;
  out_src_e         src;

  always_comb begin
    if (acc_i)           src = SRC_EVEN;
    else if (hold_valid) src = SRC_HOLD;
    else                 src = SRC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_valid  <= 1'b0;
      hold_data   <= '0;
      hold_last   <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
    end else begin
      unique case (src)
        SRC_EVEN: begin
          out_valid_o <= 1'b1;
          out_data_o  <= even_i;
          out_last_o  <= even_last_i;
          hold_valid  <= keep_odd_i;
          hold_data   <= odd_i;
          hold_last   <= odd_last_i;
        end
        SRC_HOLD: begin
          out_valid_o <= 1'b1;
          out_data_o  <= hold_data;
          out_last_o  <= hold_last;
          hold_valid  <= 1'b0;
        end
        default: begin
          out_valid_o <= 1'b0;
          out_last_o  <= 1'b0;
        end
      endcase
    end
  end

  assign hold_busy_o = hold_valid;

  a_r2_even_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> (out_valid_o && out_data_o == $past(even_i)));
  a_r3_hold_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_valid |=> (out_valid_o && out_data_o == $past(hold_data) && !hold_valid));
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !hold_valid) |=> !out_valid_o);
endmodule

// File: rtl/pix_reorder.sv
module pix_reorder #(
  parameter int PIX_W   = 12,
  parameter int MAX_LEN = 8192,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] line_len_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PIX_W-1:0] even_i,
  input  logic [PIX_W-1:0] odd_i,
  output logic             out_valid_o,
  output logic [PIX_W-1:0] out_data_o,
  output logic             out_last_o
);
  logic acc, hold_busy, last_pair, odd_len;

  assign in_ready_o = !hold_busy;
  assign acc        = in_valid_i && in_ready_o;

  pix_pair_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_len_i  (line_len_i),
    .step_i      (acc),
    .last_pair_o (last_pair),
    .odd_len_o   (odd_len)
  );

  pix_merge #(.PIX_W(PIX_W)) u_merge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .even_i      (even_i),
    .odd_i       (odd_i),
    .keep_odd_i  (!(last_pair && odd_len)),
    .even_last_i (last_pair && odd_len),
    .odd_last_i  (last_pair && !odd_len),
    .hold_busy_o (hold_busy),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o)
  );

  a_r5_last_is_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);
  a_r6_odd_tail_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && last_pair && odd_len) |=> in_ready_o);
  a_r4_held_blocks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !(last_pair && odd_len)) |=> !in_ready_o);
endmodule

// File: tb/pix_reorder_test.sv
module pix_reorder_test;
  localparam int PIX_W = 12;
  localparam int MAX_LEN = 8192;
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam logic [PIX_W-1:0] JUNK = 12'hABC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LEN_W-1:0] line_len = 14'd8;
  logic in_valid = 1'b0, in_ready, out_valid, out_last;
  logic [PIX_W-1:0] even_d = '0, odd_d = '0, out_data;

  int checks = 0, fails = 0, cyc = 0;
  logic [PIX_W-1:0] q_data[$];
  logic             q_last[$];
  int               q_cyc[$];
  int               first_acc_cyc;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pix_reorder #(.PIX_W(PIX_W), .MAX_LEN(MAX_LEN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_len_i(line_len),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .even_i(even_d), .odd_i(odd_d),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last)
  );

  always @(negedge clk) if (rst_n && out_valid) begin
    q_data.push_back(out_data);
    q_last.push_back(out_last);
    q_cyc.push_back(cyc);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives n_lines lines; lengths in lens, pixel values from base
  task automatic run_lines(input int lens[], input int base, input string req);
    int total = 0, idx = 0;
    q_data.delete(); q_last.delete(); q_cyc.delete();
    @(negedge clk);
    foreach (lens[l]) begin
      line_len = LEN_W'(lens[l]);
      for (int k = 0; k < (lens[l] + 1) / 2; k++) begin
        bit keep = (2 * k + 1) < lens[l];
        in_valid = 1'b1;
        even_d = PIX_W'(base + total + 2 * k);
        odd_d  = keep ? PIX_W'(base + total + 2 * k + 1) : JUNK;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        if (l == 0 && k == 0) first_acc_cyc = cyc;
        if (k == 0 || !keep)
          chk(in_ready == !keep, keep ? "R4" : "R6", in_ready, !keep);
      end
      total += lens[l];
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(q_data.size() == total, {req, "/R5"}, q_data.size(), total);
    if (q_data.size() == total) begin
      chk(q_cyc[0] == first_acc_cyc, "R2", q_cyc[0], first_acc_cyc);
      foreach (lens[l]) begin
        for (int i = 0; i < lens[l]; i++) begin
          logic [PIX_W-1:0] exp_d = PIX_W'(base + idx);
          bit exp_l = (i == lens[l] - 1);
          if (q_data[idx] != exp_d) chk(0, {req, "/R5 data"}, q_data[idx], exp_d);
          if (q_last[idx] != exp_l) chk(0, {req, "/R5 last"}, q_last[idx], exp_l);
          if (q_cyc[idx] != q_cyc[0] + idx) chk(0, "R3 spacing", q_cyc[idx], q_cyc[0] + idx);
          idx++;
        end
      end
      chk(1, {req, " order"}, 0, 0);
    end
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(out_last == 1'b0, "R1 last", out_last, 0);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
  endtask

  task automatic t_idle;
    int n0 = q_data.size();
    repeat (10) @(negedge clk);
    chk(q_data.size() == n0, "R8 idle", q_data.size(), n0);
  endtask

  task automatic t_discard;
    int lens[] = '{5};
    run_lines(lens, 200, "R6");
    foreach (q_data[i]) if (q_data[i] == JUNK) chk(0, "R6 junk seen", q_data[i], 0);
    chk(q_last[q_last.size()-1] == 1'b1, "R6 last on even", q_last[q_last.size()-1], 1);
  endtask

  initial begin
    fork
      begin
        #12;
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        begin int l[] = '{8};          run_lines(l, 16, "R2"); end
        begin int l[] = '{2};          run_lines(l, 40, "R3"); end
        t_discard();
        begin int l[] = '{1};          run_lines(l, 7, "R6 len1"); end
        begin int l[] = '{6, 3, 4};    run_lines(l, 300, "R7"); end
        begin int l[] = '{MAX_LEN};    run_lines(l, 0, "R5 max"); end
        t_idle();
      end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule